// File: doc/BRIEF.md
# Smart Card Power-Down Sequencer

This block owns the session state of a smart card slot and tears the card contact signals down in a fixed, timed order. The host opens a session by pulling its active-low power request low while a card is seated and no earlier fault is pending; the block then enables the card supply, releases reset high, lets the card clock through and puts the data line in receive mode. The session ends when the host lets the request return high, or at once when one of four hardware fault inputs asserts or the card is pulled out while the session runs.

Teardown always runs in the same order: reset is dropped, the card clock is gated off on a low phase, the data line is driven low and receive mode is left, and finally the supply enable is removed. A programmable discharge wait follows before the block reports idle again. The block is clocked directly by the 1.5 MHz oscillator, so every state lasts a whole number of oscillator ticks. An active-low status output shows card presence outside a session and a fault flag during one; a fault is held until the host withdraws its request, so the cause can be read after the teardown.

Top module: `card_deact_seq`

## Requirements
- R1: While reset is held and right after it, `idle` is 1, `vcc_en`, `card_rst` and `card_clk` are 0, `io_low` is 1 and `rx_en` is 0.
- R2: A session starts (at the next clock edge `vcc_en`=1, `card_rst`=1, `rx_en`=1, `io_low`=0, `idle`=0, `card_clk` follows `cclk_src`) only from idle with `pwr_req_n`=0, `card_present`=1 and no held fault; otherwise the block stays idle.
- R3: When `pwr_req_n`=1, `stat_n` equals `card_present`, the fault inputs have no effect on it, and an idle block stays idle.
- R4: If the edge that ends a session is edge k, `card_rst` is 1 up to edge k+T1 and 0 after it (T1=1).
- R5: The card clock is gated off at the first edge e with e ≥ k+T1+T2 (T2=12) at which `cclk_src` was sampled low; before that `card_clk` equals `cclk_src`, afterwards it is 0.
- R6: With c the clock-stop edge, `io_low` rises and `rx_en` falls at edge c+T3, and `vcc_en` falls at edge c+T3+T4 (T3=T4=1).
- R7: `idle` rises at edge c+T3+T4+`disch_len`+1.
- R8: During an active session with `pwr_req_n`=0, any of `flt_vec[0..3]` high or `card_present` low drives `stat_n` low in the same cycle, and the teardown starts at the next edge.
- R9: A fault that ended a session keeps `stat_n` low (while `pwr_req_n`=0) through the teardown and in idle, and blocks a new session, until `pwr_req_n` returns to 1.
- R10: Once teardown has started, fault inputs, card presence and `pwr_req_n` changes do not alter its timing or re-enable any signal before idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.5 MHz oscillator clock, one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_req_n | input | 1 | Host power request, low asks for a session |
| card_present | input | 1 | Card seated in the slot |
| flt_vec | input | 4 | Fault inputs: overcurrent, overtemperature, logic supply, card supply |
| cclk_src | input | 1 | Free-running card clock from the clock generator |
| disch_len | input | CNT_W | Extra ticks of supply discharge wait |
| card_rst | output | 1 | Card reset line |
| card_clk | output | 1 | Gated card clock |
| io_low | output | 1 | Force the card data line low |
| rx_en | output | 1 | Data line in receive mode |
| vcc_en | output | 1 | Card supply enable |
| stat_n | output | 1 | Active-low presence / fault status |
| idle | output | 1 | Teardown finished, no session |

## Verification
A wrong sequencer state shows at the contact pins on the very next tick: a state entered early or late moves the falling edge of `card_rst`, the clock gating, the data-line release or the supply drop by whole cycles, so every tick of every teardown is compared with the edge numbers computed from the trigger edge and the card clock phase. A lost or stuck fault flag shows on `stat_n` immediately while the request is low and as a refused or wrongly granted session one edge after the request. The sweep covers every trigger source against several card clock periods and phases, with disturbances injected mid-teardown.

// File: rtl/card_deact_pkg.sv
// Shared types of the card power-down sequencer.
package card_deact_pkg;

    // Session / teardown states, in teardown order.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_W_RST  = 3'd2,
        ST_W_CLK  = 3'd3,
        ST_W_IO   = 3'd4,
        ST_W_VCC  = 3'd5,
        ST_DISCH  = 3'd6
    } deact_state_t;

endpackage

// File: rtl/deact_step_timer.sv
// Tick counter for the sequencer steps.
// Counts clock ticks since the last restart and saturates at all ones.
// Assumes the clock is the oscillator, so one cycle equals one tick.
module deact_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] ticks
);

    // Clear on restart, otherwise count up and hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks <= '0;
        end else if (restart) begin
            ticks <= '0;
        end else if (ticks != {CNT_W{1'b1}}) begin
            ticks <= ticks + 1'b1;
        end
    end

endmodule

// File: rtl/deact_fault_latch.sv
// Fault capture and status output.
// A fault or card loss while a session is active with the request low trips
// the teardown and is held until the host raises its request in idle.
// Assumes the fault inputs are already synchronous to clk.
module deact_fault_latch #(
    parameter int NFLT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_active,
    input  logic            in_idle,
    input  logic            pwr_req_n,
    input  logic            card_present,
    input  logic [NFLT-1:0] flt_vec,
    output logic            trip,
    output logic            held,
    output logic            stat_n
);

    // Trip condition: only a live session with the request still low.
    always_comb begin
        trip = in_active && !pwr_req_n && ((|flt_vec) || !card_present);
    end

    // Hold the fault until the host withdraws its request in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (trip) begin
            held <= 1'b1;
        end else if (in_idle && pwr_req_n) begin
            held <= 1'b0;
        end
    end

    // Status: presence outside a session, fault flag inside one.
    always_comb begin
        if (pwr_req_n) begin
            stat_n = card_present;
        end else begin
            stat_n = !(held || trip);
        end
    end

endmodule

// File: rtl/deact_seq_fsm.sv
// Session and teardown state machine.
// Each wait state lasts its tick count, measured by the step timer, which
// restarts on every state change. The clock step also waits for a low card
// clock phase so the gated clock never shows a short high pulse.
module deact_seq_fsm
    import card_deact_pkg::*;
#(
    parameter int T1    = 1,
    parameter int T2    = 12,
    parameter int T3    = 1,
    parameter int T4    = 1,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_ok,
    input  logic             host_off,
    input  logic             fault_trip,
    input  logic             cclk_src,
    input  logic [CNT_W-1:0] ticks,
    input  logic [CNT_W-1:0] disch_len,
    output deact_state_t     state,
    output logic             restart
);

    localparam logic [CNT_W-1:0] T1_LAST = CNT_W'(T1 - 1);
    localparam logic [CNT_W-1:0] T2_LAST = CNT_W'(T2 - 1);
    localparam logic [CNT_W-1:0] T3_LAST = CNT_W'(T3 - 1);
    localparam logic [CNT_W-1:0] T4_LAST = CNT_W'(T4 - 1);

    deact_state_t nxt;

    // Next-state choice; teardown states ignore every outside input but the card clock.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (act_ok) nxt = ST_ACTIVE;
            ST_ACTIVE: if (fault_trip || host_off) nxt = ST_W_RST;
            ST_W_RST:  if (ticks >= T1_LAST) nxt = ST_W_CLK;
            ST_W_CLK:  if (ticks >= T2_LAST && !cclk_src) nxt = ST_W_IO;
            ST_W_IO:   if (ticks >= T3_LAST) nxt = ST_W_VCC;
            ST_W_VCC:  if (ticks >= T4_LAST) nxt = ST_DISCH;
            ST_DISCH:  if (ticks >= disch_len) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Restart the step timer whenever the state moves.
    always_comb begin
        restart = (nxt != state);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/card_deact_seq.sv
// Top of the card power-down sequencer.
// Tracks the session, captures faults and drives the card contacts from the
// sequencer state. Runs on the 1.5 MHz oscillator; cclk_src must be
// synchronous to it.
module card_deact_seq
    import card_deact_pkg::*;
#(
    parameter int T1    = 1,
    parameter int T2    = 12,
    parameter int T3    = 1,
    parameter int T4    = 1,
    parameter int CNT_W = 8,
    parameter int NFLT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_req_n,
    input  logic             card_present,
    input  logic [NFLT-1:0]  flt_vec,
    input  logic             cclk_src,
    input  logic [CNT_W-1:0] disch_len,
    output logic             card_rst,
    output logic             card_clk,
    output logic             io_low,
    output logic             rx_en,
    output logic             vcc_en,
    output logic             stat_n,
    output logic             idle
);

    deact_state_t     state;
    logic             restart;
    logic [CNT_W-1:0] ticks;
    logic             trip;
    logic             held;
    logic             in_active;
    logic             in_idle;
    logic             act_ok;
    logic             host_off;

    // Session gating terms.
    always_comb begin
        in_active = (state == ST_ACTIVE);
        in_idle   = (state == ST_IDLE);
        act_ok    = in_idle && !pwr_req_n && card_present && !held;
        host_off  = pwr_req_n;
    end

    deact_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ticks   (ticks)
    );

    deact_fault_latch #(.NFLT(NFLT)) u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_active    (in_active),
        .in_idle      (in_idle),
        .pwr_req_n    (pwr_req_n),
        .card_present (card_present),
        .flt_vec      (flt_vec),
        .trip         (trip),
        .held         (held),
        .stat_n       (stat_n)
    );

    deact_seq_fsm #(
        .T1(T1), .T2(T2), .T3(T3), .T4(T4), .CNT_W(CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_ok     (act_ok),
        .host_off   (host_off),
        .fault_trip (trip),
        .cclk_src   (cclk_src),
        .ticks      (ticks),
        .disch_len  (disch_len),
        .state      (state),
        .restart    (restart)
    );

    // Contact drive decoded from the state.
    always_comb begin
        card_rst = (state == ST_ACTIVE) || (state == ST_W_RST);
        card_clk = cclk_src && ((state == ST_ACTIVE) || (state == ST_W_RST) || (state == ST_W_CLK));
        rx_en    = (state == ST_ACTIVE) || (state == ST_W_RST) || (state == ST_W_CLK) || (state == ST_W_IO);
        io_low   = !rx_en;
        vcc_en   = !in_idle && (state != ST_DISCH);
        idle     = in_idle;
    end

endmodule

// File: rtl/card_deact_seq_chk.sv
// Port-level checker for the card power-down sequencer, bound to the top.
module card_deact_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_req_n,
    input logic card_present,
    input logic card_rst,
    input logic card_clk,
    input logic io_low,
    input logic vcc_en,
    input logic idle
);

    AST_SUPPLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_en |-> (!card_rst && io_low && !card_clk)); // R6

    AST_IO_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        io_low |-> !card_clk); // R6

    AST_RST_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (vcc_en && !io_low)); // R4

    AST_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && pwr_req_n) |=> idle); // R3

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> $past(!pwr_req_n && card_present)); // R2

    AST_SUPPLY_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!vcc_en && !idle) |=> !vcc_en); // R10

    AST_RST_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_rst && !idle) |=> !card_rst); // R10

endmodule

bind card_deact_seq card_deact_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_req_n    (pwr_req_n),
    .card_present (card_present),
    .card_rst     (card_rst),
    .card_clk     (card_clk),
    .io_low       (io_low),
    .vcc_en       (vcc_en),
    .idle         (idle)
);

// File: tb/card_deact_seq_test.sv
// Sweep bench: every trigger source against several card clock periods and phases.
module card_deact_seq_test;

    localparam int T1 = 1;
    localparam int T2 = 12;
    localparam int T3 = 1;
    localparam int T4 = 1;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_req_n = 1'b1;
    logic          card_present = 1'b0;
    logic [3:0]    flt_vec = '0;
    logic          cclk_src = 1'b0;
    logic [CW-1:0] disch_len = '0;
    logic card_rst, card_clk, io_low, rx_en, vcc_en, stat_n, idle;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int hh = 1;
    int off = 0;

    card_deact_seq #(.T1(T1), .T2(T2), .T3(T3), .T4(T4), .CNT_W(CW), .NFLT(4)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_req_n(pwr_req_n), .card_present(card_present),
        .flt_vec(flt_vec), .cclk_src(cclk_src), .disch_len(disch_len),
        .card_rst(card_rst), .card_clk(card_clk), .io_low(io_low), .rx_en(rx_en),
        .vcc_en(vcc_en), .stat_n(stat_n), .idle(idle)
    );

    always #2.5 clk = ~clk;

    function automatic logic fclk(int e);
        return (((e + off) / hh) % 2) == 1;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1 cclk_src = fclk(cyc);
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b cyc=%0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic run_case(int trig, int h, int o);
        int k;
        int c;
        int end_e;
        int d;
        logic exp_stat;
        hh = h;
        off = o;
        d = (trig * 5 + h * o) % 9;
        disch_len = CW'(d);
        @(posedge clk); #1 pwr_req_n = 1'b1; card_present = 1'b1; flt_vec = '0;
        @(posedge clk); #1 pwr_req_n = 1'b0;
        @(posedge clk); #2;
        chk("R2", "vcc_en on start", vcc_en, 1'b1);
        chk("R2", "card_rst on start", card_rst, 1'b1);
        chk("R2", "rx_en on start", rx_en, 1'b1);
        chk("R2", "idle on start", idle, 1'b0);
        repeat (o + 2) @(posedge clk);
        #1;
        if (trig == 0) pwr_req_n = 1'b1;
        else if (trig == 5) card_present = 1'b0;
        else flt_vec[trig-1] = 1'b1;
        #1;
        k = cyc + 1;
        if (trig == 0) chk("R4", "stat_n on host end", stat_n, 1'b1);
        else chk("R8", "stat_n same cycle as fault", stat_n, 1'b0);
        chk("R8", "supply still on before edge", vcc_en, 1'b1);
        c = k + T1 + T2;
        while (fclk(c - 1)) c++;
        end_e = c + T3 + T4 + d + 1;
        for (int e = k; e <= end_e + 1; e++) begin
            @(posedge clk); #1;
            if (e == k) flt_vec = '0;
            if (e == k + 2) begin flt_vec = 4'hF; pwr_req_n = ~pwr_req_n; end
            if (e == k + 3) begin flt_vec = '0; pwr_req_n = ~pwr_req_n; end
            #1;
            chk("R4", "card_rst", card_rst, e < k + T1);
            chk("R5", "card_clk", card_clk, (e < c) ? fclk(e) : 1'b0);
            chk("R6", "io_low", io_low, e >= c + T3);
            chk("R6", "rx_en", rx_en, e < c + T3);
            chk("R6", "vcc_en", vcc_en, e < c + T3 + T4);
            chk("R7", "idle", idle, e >= end_e);
            exp_stat = pwr_req_n ? card_present : (trig == 0);
            chk("R10", "stat_n during teardown", stat_n, exp_stat);
        end
        if (trig != 0) begin
            card_present = 1'b1;
            repeat (2) @(posedge clk);
            #2;
            chk("R9", "no restart with held fault", idle, 1'b1);
            chk("R9", "supply off with held fault", vcc_en, 1'b0);
            chk("R9", "stat_n held low", stat_n, 1'b0);
            pwr_req_n = 1'b1;
            #1 chk("R3", "stat_n shows presence", stat_n, 1'b1);
        end else begin
            chk("R3", "stat_n after host end", stat_n, 1'b1);
        end
        @(posedge clk); #1 card_present = 1'b0; flt_vec = 4'hF;
        repeat (3) begin
            @(posedge clk); #2;
            chk("R3", "stat_n no card outside session", stat_n, 1'b0);
            chk("R3", "idle kept outside session", idle, 1'b1);
        end
        #1 card_present = 1'b1;
        #1 chk("R3", "stat_n faults ignored outside session", stat_n, 1'b1);
        flt_vec = '0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "idle in reset", idle, 1'b1);
        chk("R1", "vcc_en in reset", vcc_en, 1'b0);
        chk("R1", "card_rst in reset", card_rst, 1'b0);
        chk("R1", "card_clk in reset", card_clk, 1'b0);
        chk("R1", "io_low in reset", io_low, 1'b1);
        chk("R1", "rx_en in reset", rx_en, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1", "idle after reset", idle, 1'b1);
        // No card: request refused.
        pwr_req_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R2", "no start without card", idle, 1'b1);
        chk("R2", "no supply without card", vcc_en, 1'b0);
        pwr_req_n = 1'b1;
        @(posedge clk); #1;
        for (int t = 0; t < 6; t++)
            for (int h = 1; h <= 3; h++)
                for (int o = 0; o < 3; o++)
                    run_case(t, h, o);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule